// File: doc/BRIEF.md
# Bidirectional Open-Drain Repeater Lane Controller

This block controls the pull-down transistors of a repeater that joins two segments of a wired-AND, open-drain bus. Each lane has an A side and a B side. Every side provides a sensed level, which is the wired-AND of all external drivers and the block's own pull-down, and every side takes a pull-down request. When one side is pulled low by an outside driver, the lane pulls the other side low and keeps doing so until the outside driver lets go. Either side can start a transfer. The lane records which side started it, so the low that it drives onto the far side is never mistaken for a new outside drive. Without that record the two pull-downs would hold each other low for ever.

Lanes are parameterised (default two: lane 0 carries the clock line, lane 1 the data line) and run independently of each other. The sensed levels are resynchronised inside the block. A connect input from a start-up sequencer isolates the two sides whenever it is low. After every release the lane ignores both sides for a short blanking window, while the synchronised copy of the side it had been driving returns high.

Top module: `od_repeater`

## Requirements
- R1: From idle with connect high, a low sensed on A of a lane (sense bit 0 = line low) sets that lane's b_pull_o bit (1 = pull low) after the third rising edge that follows the change, with SYNC_STAGES = 2. Direction is then A-to-B.
- R2: From idle with connect high, a low sensed on B sets that lane's a_pull_o bit after the same latency. Direction is then B-to-A.
- R3: a_pull_o and b_pull_o of a lane are never 1 together. While a lane drives one side low, the low it reads back on that side never starts the reverse direction.
- R4: The pull-down stays asserted while the active input side reads low. The pull-down is released after the third rising edge following that side's return high.
- R5: Direction is not fixed. After a B-to-A transfer has finished, the same lane carries an A-to-B transfer, and the reverse also holds.
- R6: Lanes are independent. Lane 0 can run A-to-B while lane 1 runs B-to-A at the same time.
- R7: While connect_i is low, both pull-down outputs of every lane are 0 after the next rising edge, whatever the sides read. After connect_i rises, a lane whose A side is held low starts an A-to-B transfer with b_pull_o set after the fourth rising edge.
- R8: When both sides of an idle lane first read low in the same cycle, A wins. b_pull_o is set and a_pull_o stays 0.
- R9: After a release, the lane ignores both sides for SYNC_STAGES+1 cycles. A B side still held low externally (clock stretching) during an A-to-B transfer sets a_pull_o after the seventh rising edge following the release of A, and never sooner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| connect_i | input | 1 | Sequencer permission to join the sides; low isolates |
| a_sense_i | input | LANES | Sensed A-side level per lane, 0 = low |
| b_sense_i | input | LANES | Sensed B-side level per lane, 0 = low |
| a_pull_o | output | LANES | Pull A side low per lane, 1 = pull |
| b_pull_o | output | LANES | Pull B side low per lane, 1 = pull |

## Verification
The bench models outside open-drain drivers on both sides, so every pull the block makes shows up in its own sensed inputs. That is the echo a design without a direction lock would latch on, and it would show as both pulls stuck high. Directed cases cover simultaneous lows, where a design lacking A priority would drive A. They cover B-side clock stretching across an A transfer, where a design without a blanking window would either act on the stale low too early or drop the stretch. They also cover opposite directions on the two lanes, where shared state would cross-couple them, and a connect drop in mid-transfer, where a design would leave a pull stuck. A seeded random phase then compares every cycle against a bench model written from the requirements.

// File: rtl/od_repeater_pkg.sv
package od_repeater_pkg;
  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_A2B   = 2'd1,
    LN_B2A   = 2'd2,
    LN_BLANK = 2'd3
  } lane_state_e;
endpackage

// File: rtl/od_level_sync.sv
module od_level_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      // idle bus reads high
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int s = 0; s < STAGES; s++) stg[s] <= '1;
        end else begin
          stg[0] <= d_i;
          for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
      end
      assign q_o = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/od_lane_ctrl.sv
module od_lane_ctrl
  import od_repeater_pkg::*;
#(
  parameter int BLANK_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic connect_i,
  input  logic a_low_i,
  input  logic b_low_i,
  output logic a_pull_o,
  output logic b_pull_o
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] BLANK_LOAD = CW'(BLANK_CYC - 1);

  lane_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!connect_i) begin
      st_d  = LN_BLANK;
      cnt_d = BLANK_LOAD;
    end else begin
      unique case (st_q)
        LN_IDLE: begin
          if (a_low_i)      st_d = LN_A2B;  // A wins a tie
          else if (b_low_i) st_d = LN_B2A;
        end
        LN_A2B: begin
          if (!a_low_i) begin
            st_d  = LN_BLANK;
            cnt_d = BLANK_LOAD;
          end
        end
        LN_B2A: begin
          if (!b_low_i) begin
            st_d  = LN_BLANK;
            cnt_d = BLANK_LOAD;
          end
        end
        default: begin
          if (cnt_q == '0) st_d = LN_IDLE;
          else             cnt_d = cnt_q - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign a_pull_o = (st_q == LN_B2A);
  assign b_pull_o = (st_q == LN_A2B);
endmodule

// File: rtl/od_repeater.sv
module od_repeater #(
  parameter int LANES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             connect_i,
  input  logic [LANES-1:0] a_sense_i,
  input  logic [LANES-1:0] b_sense_i,
  output logic [LANES-1:0] a_pull_o,
  output logic [LANES-1:0] b_pull_o
);
  localparam int W         = 2 * LANES;
  localparam int BLANK_CYC = SYNC_STAGES + 1;

  logic [W-1:0]     lvl;
  logic [LANES-1:0] a_lvl, b_lvl;

  od_level_sync #(.STAGES(SYNC_STAGES), .WIDTH(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({b_sense_i, a_sense_i}),
    .q_o    (lvl)
  );

  assign a_lvl = lvl[LANES-1:0];
  assign b_lvl = lvl[W-1:LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    od_lane_ctrl #(.BLANK_CYC(BLANK_CYC)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .connect_i (connect_i),
      .a_low_i   (~a_lvl[l]),
      .b_low_i   (~b_lvl[l]),
      .a_pull_o  (a_pull_o[l]),
      .b_pull_o  (b_pull_o[l])
    );
  end
endmodule

// File: rtl/od_repeater_chk.sv
module od_repeater_chk #(
  parameter int LANES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             connect_i,
  input logic [LANES-1:0] a_lvl,
  input logic [LANES-1:0] b_lvl,
  input logic [LANES-1:0] a_pull_o,
  input logic [LANES-1:0] b_pull_o
);
  p_no_dual_pull_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_pull_o & b_pull_o) == '0);

  p_isolate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !connect_i |=> (a_pull_o == '0 && b_pull_o == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    p_start_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(b_pull_o[l]) |-> ($past(connect_i) && !$past(a_lvl[l])));

    p_start_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(a_pull_o[l]) |-> ($past(connect_i) && !$past(b_lvl[l])));

    p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (connect_i && b_pull_o[l] && a_lvl[l]) |=> !b_pull_o[l]);

    p_a_priority_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (connect_i && !a_pull_o[l] && !b_pull_o[l] && !a_lvl[l] && !b_lvl[l])
        |=> !a_pull_o[l]);

    p_blank_ab_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(b_pull_o[l]) |=> !a_pull_o[l]);

    p_blank_ba_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(a_pull_o[l]) |=> !b_pull_o[l]);
  end
endmodule

bind od_repeater od_repeater_chk #(.LANES(LANES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .connect_i (connect_i),
  .a_lvl     (a_lvl),
  .b_lvl     (b_lvl),
  .a_pull_o  (a_pull_o),
  .b_pull_o  (b_pull_o)
);

// File: tb/tb_od_repeater.sv
`timescale 1ns/1ps
module tb_od_repeater;
  localparam int LANES = 2;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic connect = 1'b1;
  logic [LANES-1:0] ext_a = '0, ext_b = '0;
  logic [LANES-1:0] a_sense, b_sense, a_pull, b_pull;
  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  assign a_sense = ~(ext_a | a_pull);
  assign b_sense = ~(ext_b | b_pull);

  od_repeater #(.LANES(LANES), .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .connect_i(connect),
    .a_sense_i(a_sense), .b_sense_i(b_sense),
    .a_pull_o(a_pull), .b_pull_o(b_pull)
  );

  // reference model: 0 idle, 1 A-to-B, 2 B-to-A, 3 blanking
  int m_st [LANES];
  int m_cnt [LANES];
  logic [SYNC-1:0] m_pa [LANES];
  logic [SYNC-1:0] m_pb [LANES];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        m_st[l] <= 0; m_cnt[l] <= 0; m_pa[l] <= '1; m_pb[l] <= '1;
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        m_pa[l] <= {m_pa[l][0], a_sense[l]};
        m_pb[l] <= {m_pb[l][0], b_sense[l]};
        if (!connect) begin
          m_st[l] <= 3; m_cnt[l] <= SYNC;
        end else begin
          case (m_st[l])
            0: if (!m_pa[l][SYNC-1]) m_st[l] <= 1;
               else if (!m_pb[l][SYNC-1]) m_st[l] <= 2;
            1: if (m_pa[l][SYNC-1]) begin m_st[l] <= 3; m_cnt[l] <= SYNC; end
            2: if (m_pb[l][SYNC-1]) begin m_st[l] <= 3; m_cnt[l] <= SYNC; end
            default: if (m_cnt[l] == 0) m_st[l] <= 0; else m_cnt[l] <= m_cnt[l] - 1;
          endcase
        end
      end
    end
  end

  task automatic chk(string req, int lane, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s lane %0d: got %0b expected %0b", req, lane, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    rst_n = 1'b1;
    step(2);
    // reset state
    for (int l = 0; l < LANES; l++) begin
      chk("R3 reset a_pull", l, a_pull[l], 1'b0);
      chk("R3 reset b_pull", l, b_pull[l], 1'b0);
    end

    // R1: A low -> B pulled, echo ignored
    ext_a[0] = 1'b1;
    step(2); chk("R1 latency early", 0, b_pull[0], 1'b0);
    step(1); chk("R1 b pulled", 0, b_pull[0], 1'b1);
    step(5); chk("R3 echo ignored", 0, a_pull[0], 1'b0);
    chk("R4 held", 0, b_pull[0], 1'b1);
    chk("R6 lane1 untouched", 1, b_pull[1], 1'b0);
    // R4 release
    ext_a[0] = 1'b0;
    step(2); chk("R4 still held", 0, b_pull[0], 1'b1);
    step(1); chk("R4 released", 0, b_pull[0], 1'b0);
    step(10); chk("R9 no echo start", 0, a_pull[0], 1'b0);
    chk("R9 no restart", 0, b_pull[0], 1'b0);

    // R2 mirror
    ext_b[0] = 1'b1;
    step(3); chk("R2 a pulled", 0, a_pull[0], 1'b1);
    chk("R3 b not pulled", 0, b_pull[0], 1'b0);
    ext_b[0] = 1'b0;
    step(3); chk("R4 a released", 0, a_pull[0], 1'b0);
    step(6);

    // R5 direction reversal on same lane
    ext_a[0] = 1'b1;
    step(3); chk("R5 A-to-B after B-to-A", 0, b_pull[0], 1'b1);
    ext_a[0] = 1'b0;
    step(10);

    // R8 tie
    ext_a[1] = 1'b1; ext_b[1] = 1'b1;
    step(3); chk("R8 tie b pulled", 1, b_pull[1], 1'b1);
    chk("R8 tie a free", 1, a_pull[1], 1'b0);
    ext_a[1] = 1'b0; ext_b[1] = 1'b0;
    step(10);

    // R9 clock stretch from B during A transfer
    ext_a[0] = 1'b1;
    step(3); chk("R9 transfer up", 0, b_pull[0], 1'b1);
    ext_b[0] = 1'b1;
    step(2);
    ext_a[0] = 1'b0;
    step(3); chk("R9 b released", 0, b_pull[0], 1'b0);
    chk("R9 blank a", 0, a_pull[0], 1'b0);
    step(3); chk("R9 still blank", 0, a_pull[0], 1'b0);
    step(1); chk("R9 stretch passed", 0, a_pull[0], 1'b1);
    chk("R9 A line low", 0, a_sense[0], 1'b0);
    ext_b[0] = 1'b0;
    step(3); chk("R9 stretch end", 0, a_pull[0], 1'b0);
    step(10);

    // R6 opposite directions on two lanes
    ext_a[0] = 1'b1; ext_b[1] = 1'b1;
    step(3);
    chk("R6 lane0 A-to-B", 0, b_pull[0], 1'b1);
    chk("R6 lane0 a free", 0, a_pull[0], 1'b0);
    chk("R6 lane1 B-to-A", 1, a_pull[1], 1'b1);
    chk("R6 lane1 b free", 1, b_pull[1], 1'b0);
    ext_a[0] = 1'b0; ext_b[1] = 1'b0;
    step(10);

    // R7 connect drop mid transfer
    ext_a[0] = 1'b1;
    step(3); chk("R7 pre", 0, b_pull[0], 1'b1);
    connect = 1'b0;
    step(1); chk("R7 isolated b", 0, b_pull[0], 1'b0);
    step(5); chk("R7 stays isolated", 0, b_pull[0], 1'b0);
    chk("R7 a isolated", 0, a_pull[0], 1'b0);
    connect = 1'b1;
    step(3); chk("R7 blank after reconnect", 0, b_pull[0], 1'b0);
    step(1); chk("R7 reconnect transfer", 0, b_pull[0], 1'b1);
    ext_a[0] = 1'b0;
    step(10);

    // random phase against model
    cmp_en = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      for (int l = 0; l < LANES; l++) begin
        chk("R1/R2/R4/R9 model b", l, b_pull[l], (m_st[l] == 1));
        chk("R1/R2/R4/R9 model a", l, a_pull[l], (m_st[l] == 2));
        chk("R3 no dual", l, a_pull[l] & b_pull[l], 1'b0);
        if ($urandom % 6 == 0) ext_a[l] = ~ext_a[l];
        if ($urandom % 6 == 0) ext_b[l] = ~ext_b[l];
      end
      if (!connect) connect = ($urandom % 4 == 0);
      else if ($urandom % 150 == 0) connect = 1'b0;
      step(1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule